// File: doc/BRIEF.md
# Byte-at-a-time SPI Master

This block is a serial peripheral interface master that moves exactly one 8-bit word per start command. It has no buffering. A host reaches it through a small byte-wide register window on a simple synchronous bus with a write strobe, a read strobe and a 3-bit address. Writes take effect on the clock edge. Read data is combinational from the address.

Software configures the block in three steps. It writes the clock divisor and the mode byte, places a byte in the transmit register, and writes the start bit. The block then runs eight serial clock cycles. It shifts the transmit byte out on MOSI while it assembles a byte from MISO, or from its own output when loopback is selected. At the end it raises a receive-ready flag, which is also the interrupt. Reading the receive register clears that flag. All four clock polarity and phase combinations are supported, in both bit orders. Chip-select generation is left to the surrounding logic.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, every register reads 0x00, `irq` is low, `sck` is low and `mosi` is low.
- R2: The mode register (address 0) holds five bits and reads back what was written in those bits. The masks are 0x10 sample-on-leading-edge, 0x08 port enable, 0x04 LSB first, 0x02 clock idles high and 0x01 loopback. Its upper three bits read 0. The transmit register (address 2) and the divisor register (address 6) read back their full byte. The control register (address 3) and the reserved location (address 5) always read 0x00, and writes to them store nothing.
- R3: Writing a value with bit 0x01 set to address 3 starts a transfer when the port is enabled and idle. From the next cycle, status (address 4) bit 0x02 reads busy.
- R4: Within a transfer, successive leading SCK edges are exactly 4×(D+1) bus clocks apart, where D is the divisor register value.
- R5: Whenever no transfer is running, `sck` sits at the level given by the idle-high bit. While the port enable bit is 0, `mosi` is driven low.
- R6: With the sample-on-leading-edge bit set, both sides sample data on the leading SCK edge and change it on the trailing edge. With the bit clear, data changes on the leading edge and is sampled on the trailing edge. In both cases the received byte equals the byte the slave sent, and the slave sees the transmitted byte.
- R7: With the LSB-first bit set, bit 0 is shifted first in both directions. With it clear, bit 7 goes first.
- R8: With the loopback bit set, the received byte equals the transmitted byte and MISO has no effect.
- R9: When a byte completes, status bit 0x01 (receive ready) and `irq` go high. Busy is still high in that first cycle and low in the cycle after.
- R10: Reading address 1 returns the received byte and clears receive ready and `irq` from the next cycle.
- R11: A start request is ignored while a transfer is in progress and while the port is disabled. The byte in flight on MOSI is unchanged, and no further transfer follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (read side effects) |
| busAddr | input | 3 | Register byte address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr |
| irq | output | 1 | Interrupt, level of receive ready |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest condition to bring about is the one-cycle window in which receive ready is already high while busy is still high. Seeing it needs a status sample in every bus cycle. The stimulus therefore holds a status read on the bus continuously while waiting for the interrupt, and checks busy in the first cycle the interrupt is seen and again one cycle later. A behavioural slave follows the SCK edges to drive MISO and rebuild the MOSI byte in all four clock modes, in both bit orders and at several divisors. This covers edge placement without probing internal state. A second start, issued midway through a byte with a different transmit value, shows that the serial stream is not disturbed.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

  // register byte addresses
  localparam int ADDR_MODE = 0;
  localparam int ADDR_RX   = 1;
  localparam int ADDR_TX   = 2;
  localparam int ADDR_CTRL = 3;
  localparam int ADDR_STAT = 4;
  localparam int ADDR_RSVD = 5;
  localparam int ADDR_DIV  = 6;

  // first field is the MSB: masks 0x10 .. 0x01
  typedef struct packed {
    logic phaseLead;
    logic enable;
    logic lsbFirst;
    logic idleHigh;
    logic loopback;
  } modeCfg_t;

  typedef struct packed {
    logic load;
    logic shiftEn;
    logic sampleEn;
    logic capture;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } seqState_t;

endpackage

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CDM_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] rxData,
  output modeCfg_t          mode,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] txData,
  output logic              busy,
  output logic              irq,
  output logic              sckToggle
);

  localparam int DIV_W   = CDM_W + 1;
  localparam int EDGES   = 2 * DATA_W;
  localparam int EDGE_W  = $clog2(EDGES);
  localparam int MODE_W  = $bits(modeCfg_t);

  modeCfg_t          modeReg;
  logic [DATA_W-1:0] txReg;
  logic [CDM_W-1:0]  cdmReg;
  logic              rxReady;
  seqState_t         state;
  logic [DIV_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic              sckLvl;

  logic isAddrMode, isAddrTx, isAddrCtrl, isAddrDiv, isAddrRx;
  logic startReq, startOk, rdRx;
  logic [DIV_W-1:0] halfLimit;
  logic tick, leading, lastEdge;

  assign isAddrMode = busAddr == ADDR_W'(ADDR_MODE);
  assign isAddrTx   = busAddr == ADDR_W'(ADDR_TX);
  assign isAddrCtrl = busAddr == ADDR_W'(ADDR_CTRL);
  assign isAddrDiv  = busAddr == ADDR_W'(ADDR_DIV);
  assign isAddrRx   = busAddr == ADDR_W'(ADDR_RX);

  assign startReq = busWrEn && isAddrCtrl && busWrData[0];
  assign startOk  = startReq && modeReg.enable && (state == ST_IDLE);
  assign rdRx     = busRdEn && isAddrRx;

  // half SCK period is 2*(cdm+1) bus clocks
  assign halfLimit = {cdmReg, 1'b1};
  assign tick      = (state == ST_RUN) && (divCnt == halfLimit);
  assign leading   = ~edgeCnt[0];
  assign lastEdge  = edgeCnt == EDGE_W'(EDGES - 1);

  always_comb begin
    strobe.load     = startOk;
    strobe.sampleEn = tick && (modeReg.phaseLead ? leading : !leading);
    strobe.shiftEn  = tick && !lastEdge &&
                      (modeReg.phaseLead ? !leading : (leading && edgeCnt != '0));
    strobe.capture  = tick && lastEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      txReg   <= '0;
      cdmReg  <= '0;
      rxReady <= 1'b0;
      state   <= ST_IDLE;
      divCnt  <= '0;
      edgeCnt <= '0;
      sckLvl  <= 1'b0;
    end else begin
      if (busWrEn && isAddrMode) modeReg <= modeCfg_t'(busWrData[MODE_W-1:0]);
      if (busWrEn && isAddrTx)   txReg   <= busWrData;
      if (busWrEn && isAddrDiv)  cdmReg  <= busWrData[CDM_W-1:0];

      if (strobe.capture)  rxReady <= 1'b1;
      else if (rdRx)       rxReady <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          if (startOk) begin
            state   <= ST_RUN;
            divCnt  <= '0;
            edgeCnt <= '0;
            sckLvl  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            divCnt  <= '0;
            sckLvl  <= ~sckLvl;
            edgeCnt <= edgeCnt + 1'b1;
            if (lastEdge) state <= ST_TAIL;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_TAIL: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mode      = modeReg;
  assign txData    = txReg;
  assign busy      = state != ST_IDLE;
  assign irq       = rxReady;
  assign sckToggle = sckLvl;

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(ADDR_MODE): busRdData = DATA_W'(modeReg);
      ADDR_W'(ADDR_RX):   busRdData = rxData;
      ADDR_W'(ADDR_TX):   busRdData = txReg;
      ADDR_W'(ADDR_STAT): busRdData = DATA_W'({busy, rxReady});
      ADDR_W'(ADDR_DIV):  busRdData = DATA_W'(cdmReg);
      default:            busRdData = '0;
    endcase
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    startOk |=> busy);

  // R11
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !modeReg.enable && !busy) |=> !busy);

  // R9
  rdy_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> busy);

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |=> !busy);

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdRx && !strobe.capture) |=> !irq);

endmodule

// File: rtl/spi_byte_dp.sv
module spi_byte_dp
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  modeCfg_t          mode,
  input  logic [DATA_W-1:0] txData,
  input  logic              miso,
  output logic [DATA_W-1:0] rxData,
  output logic              mosi
);

  logic [DATA_W-1:0] txSr, rxSr, rxShifted, txShifted;
  logic outBit, inBit;

  assign outBit = mode.lsbFirst ? txSr[0] : txSr[DATA_W-1];
  assign inBit  = mode.loopback ? outBit : miso;
  assign mosi   = mode.enable ? outBit : 1'b0;

  assign rxShifted = mode.lsbFirst ? {inBit, rxSr[DATA_W-1:1]}
                                   : {rxSr[DATA_W-2:0], inBit};
  assign txShifted = mode.lsbFirst ? {1'b0, txSr[DATA_W-1:1]}
                                   : {txSr[DATA_W-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSr   <= '0;
      rxSr   <= '0;
      rxData <= '0;
    end else begin
      if (strobe.load) begin
        txSr <= txData;
        rxSr <= '0;
      end else begin
        if (strobe.shiftEn)  txSr <= txShifted;
        if (strobe.sampleEn) rxSr <= rxShifted;
      end
      if (strobe.capture) rxData <= strobe.sampleEn ? rxShifted : rxSr;
    end
  end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CDM_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  modeCfg_t          mode;
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] txData, rxData;
  logic              busy, sckToggle;

  spi_byte_ctrl #(.DATA_W(DATA_W), .CDM_W(CDM_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .rxData(rxData), .mode(mode), .strobe(strobe), .txData(txData),
    .busy(busy), .irq(irq), .sckToggle(sckToggle)
  );

  spi_byte_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode),
    .txData(txData), .miso(miso), .rxData(rxData), .mosi(mosi)
  );

  assign sck = mode.enable ? (mode.idleHigh ^ sckToggle) : mode.idleHigh;

  // R5
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sck == mode.idleHigh));

endmodule

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0, busRdData;
  logic irq, sck, mosi, miso = 1'b0;

  int checks = 0, fails = 0;
  logic [7:0] expTx[$];
  logic [7:0] expRx[$];

  // bench view of the mode in force
  logic tbPhase = 1'b0, tbIdle = 1'b0, tbLsb = 1'b0, monOn = 1'b0;
  int   tbCdm = 0;
  logic [7:0] slvByte = '0, gotTx = '0;
  int   slvNext = 0, bitCnt = 0, lastLead = -1, cyc = 0;
  logic prevSck = 1'b0, prevMosi = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_master u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 3'(a); busWrData = 8'(d);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = 3'(a);
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  function automatic logic slvBit(input int i);
    return tbLsb ? slvByte[i] : slvByte[7-i];
  endfunction

  // monitor: slave model and scoreboard for the MOSI stream
  always @(negedge clk) begin
    if (monOn && sck !== prevSck) begin
      logic lead;
      lead = (prevSck == tbIdle);
      if (lead) begin
        if (lastLead >= 0) chk("R4 sck leading-edge spacing", cyc - lastLead, 4*(tbCdm+1));
        lastLead = cyc;
      end
      if (lead == tbPhase) begin
        gotTx = tbLsb ? {prevMosi, gotTx[7:1]} : {gotTx[6:0], prevMosi};
        bitCnt++;
        if (bitCnt == 8) begin
          logic [7:0] e;
          e = expTx.pop_front();
          chk("R6 R7 mosi byte seen by slave", gotTx, e);
        end
      end else if (slvNext < 8) begin
        miso = slvBit(slvNext);
        slvNext++;
      end
    end
    prevSck = sck;
    prevMosi = mosi;
    cyc++;
  end

  task automatic xfer(input logic ph, input logic idle, input logic lsb, input logic loopB,
                      input int cdm, input logic [7:0] tx, input logic [7:0] slv,
                      input logic midStart);
    logic [7:0] d;
    wr(6, cdm);
    wr(0, {3'b0, ph, 1'b1, lsb, idle, loopB});
    wr(2, tx);
    tbPhase = ph; tbIdle = idle; tbLsb = lsb; tbCdm = cdm; slvByte = slv;
    slvNext = ph ? 1 : 0; miso = slvBit(0);
    bitCnt = 0; lastLead = -1; gotTx = '0;
    expTx.push_back(tx);
    expRx.push_back(loopB ? tx : slv);
    @(negedge clk);
    monOn = 1'b1;
    wr(3, 1);
    rd(4, d);
    chk("R3 busy after start", d, 8'h02);
    if (midStart) begin
      wr(2, ~tx);
      wr(3, 1); // R11 start while busy
    end
    @(negedge clk);
    busRdEn = 1'b1; busAddr = 3'd4;
    while (irq !== 1'b1) begin
      @(negedge clk);
      #1;
    end
    chk("R9 busy and ready in first irq cycle", busRdData, 8'h03);
    @(negedge clk);
    #1 chk("R9 busy low one cycle later", busRdData, 8'h01);
    busRdEn = 1'b0;
    monOn = 1'b0;
    rd(1, d);
    begin
      logic [7:0] e;
      e = expRx.pop_front();
      chk(loopB ? "R8 loopback rx byte" : "R6 R7 rx byte", d, e);
    end
    @(negedge clk);
    chk("R10 irq cleared by rx read", irq, 0);
    rd(4, d);
    chk("R10 R11 status idle after read", d, 8'h00);
    chk("R5 sck idle level", sck, idle);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 irq at reset", irq, 0);
    chk("R1 sck at reset", sck, 0);
    chk("R1 mosi at reset", mosi, 0);
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk("R1 register reset value", d, 0);
    end
    // R2
    wr(0, 8'hFF); rd(0, d); chk("R2 mode upper bits", d, 8'h1F);
    wr(0, 8'h0A); rd(0, d); chk("R2 mode readback", d, 8'h0A);
    wr(2, 8'hA5); rd(2, d); chk("R2 tx readback", d, 8'hA5);
    wr(6, 8'h3C); rd(6, d); chk("R2 divisor readback", d, 8'h3C);
    wr(5, 8'h77); rd(5, d); chk("R2 reserved reads zero", d, 8'h00);
    rd(3, d); chk("R2 control reads zero", d, 8'h00);
    // R5 R11: disabled port
    wr(0, 8'h02);
    @(negedge clk);
    chk("R5 disabled sck idles high", sck, 1);
    chk("R5 disabled mosi low", mosi, 0);
    wr(3, 1);
    repeat (4) @(negedge clk);
    rd(4, d); chk("R11 start ignored when disabled", d, 8'h00);
    chk("R11 sck unchanged when disabled", sck, 1);
    // all clock modes, both orders, several divisors
    xfer(1'b1, 1'b0, 1'b0, 1'b0, 0, 8'hA5, 8'h3C, 1'b0);
    xfer(1'b0, 1'b0, 1'b0, 1'b0, 1, 8'h5A, 8'hC3, 1'b0);
    xfer(1'b1, 1'b1, 1'b0, 1'b0, 2, 8'h81, 8'h7E, 1'b0);
    xfer(1'b0, 1'b1, 1'b0, 1'b0, 0, 8'h12, 8'hED, 1'b0);
    xfer(1'b1, 1'b0, 1'b1, 1'b0, 1, 8'h01, 8'h80, 1'b0);
    xfer(1'b0, 1'b1, 1'b1, 1'b0, 3, 8'hC4, 8'h29, 1'b0);
    // R8 loopback with opposing MISO data
    xfer(1'b1, 1'b0, 1'b0, 1'b1, 0, 8'h96, 8'h69, 1'b0);
    xfer(1'b0, 1'b1, 1'b1, 1'b1, 2, 8'h3B, 8'hFF, 1'b0);
    // R11 start while busy
    xfer(1'b1, 1'b0, 1'b0, 1'b0, 4, 8'hD2, 8'h4B, 1'b1);
    repeat (40) @(negedge clk);
    rd(4, d); chk("R11 no second transfer", d, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule